// File: doc/BRIEF.md
# Request Validator and Response Framer for a Block-Transfer Host Port

This block sits between the byte buffers of a host-facing block-transfer register port and the command-processing back end of a management controller. When the register port signals that the host has finished writing a request, the block reads the inbound buffer and checks its framing. Malformed requests are dropped. A query for the interface's capabilities is answered on the spot, without involving the back end. Every other request goes to the back end as a byte stream tagged with a rolling request ID.

Responses come back as a byte stream carrying an ID. A response whose ID matches the expected value is written into the outbound buffer as a frame. The frame is a length byte, the response's function byte, the sequence byte saved from the request, and then the remaining response bytes. If the response does not fit the buffer, a short error frame is written instead. Once a reply frame is complete, the block publishes the frame length and pulses a completion signal. The register port uses that pulse to clear its back-end busy flag and raise back-end-to-host attention.

Top module: `btf_frame_engine`

## Requirements
- R1: A request strobe with an inbound length below 4 produces no inbound clear, no back-end beat, no outbound write and no completion pulse.
- R2: If inbound byte 0 differs from the inbound length minus one, `inb_clr` pulses once. No back-end beat and no completion pulse follow, so the port's back-end busy flag stays set.
- R3: A request with byte 1 equal to 0x18 and byte 3 equal to 0x36 is answered locally with a 10-byte frame. The frame is 9, byte1|0x04, byte 2, byte 3, 0, 1, min(BUF_BYTES,255), min(BUF_BYTES,255), 10, 0, written to outbound addresses 0 to 9. The published length is 10.
- R4: Any other well-formed request is sent to the back end as byte 1 followed by bytes 3 to length-1. `be_req_last` is set on the final beat only. `be_req_id` carries the expected response ID. The data is held steady while ready is low.
- R5: The expected response ID starts at 0 after reset. It increments by one, wrapping modulo 256, each time a response is accepted.
- R6: An accepted response of N bytes (N ≤ BUF_BYTES-2) produces this frame at outbound addresses 0 to N+1: N+1, response byte 0, saved sequence byte, response bytes 1 to N-1. The published length is N+2.
- R7: An accepted response longer than BUF_BYTES-2 bytes produces the 5-byte frame 4, response byte 0, saved sequence byte, response byte 1, 0xCA. The published length is 5.
- R8: Every completed reply, local or from the back end, pulses `reply_done` in the same cycle that `ob_len_we` is high.
- R9: A response whose ID differs from the expected ID is consumed without any outbound write, completion pulse or change of the expected ID.
- R10: While a forwarded request awaits its response, a new request strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_strobe | input | 1 | Host has finished writing a request |
| inb_len | input | LEN_W | Bytes held in the inbound buffer |
| inb_addr | output | AW | Inbound buffer read address |
| inb_data | input | 8 | Inbound buffer read data (combinational read) |
| inb_clr | output | 1 | Clear the inbound byte count |
| be_req_valid | output | 1 | Back-end request beat valid |
| be_req_ready | input | 1 | Back end accepts the beat |
| be_req_data | output | 8 | Back-end request byte |
| be_req_last | output | 1 | Final beat of the request |
| be_req_id | output | 8 | Response ID the request is tagged with |
| be_rsp_valid | input | 1 | Response beat valid |
| be_rsp_ready | output | 1 | Block accepts a response beat |
| be_rsp_data | input | 8 | Response byte |
| be_rsp_last | input | 1 | Final beat of the response |
| be_rsp_id | input | 8 | Response ID, sampled on the first beat |
| ob_we | output | 1 | Outbound buffer write enable |
| ob_addr | output | AW | Outbound buffer write address |
| ob_data | output | 8 | Outbound buffer write data |
| ob_len_we | output | 1 | Load a new outbound frame length |
| ob_len | output | LEN_W | Outbound frame length |
| reply_done | output | 1 | Reply ready: clear busy, raise attention |

## Verification
The bench builds a response of exactly BUF_BYTES-2 bytes and another one byte longer. A framer with an off-by-one size limit would send the error frame for the first or overflow the buffer on the second. A response with a foreign ID is followed by a correctly tagged one. A design that counted the stray response would bump its ID and then reject the real reply. A second request issued while the first is still pending must not reach the back end; a design that let it through would overwrite the saved sequence byte. The bench runs 256 round trips, so an ID that stuck or failed to wrap would tag a request wrongly.

// File: rtl/btf_pkg.sv
package btf_pkg;

    localparam logic [7:0] APP_FN_BYTE = 8'h18;  // application function code << 2
    localparam logic [7:0] CAP_CMD     = 8'h36;  // capability query command
    localparam logic [7:0] CC_TOO_BIG  = 8'hCA;  // cannot return requested byte count
    localparam logic [7:0] RSP_BIT     = 8'h04;  // response marker in function byte

    typedef enum logic [2:0] {
        CK_IDLE,
        CK_LEN,
        CK_FN,
        CK_SEQ,
        CK_CMD,
        CK_CAP,
        CK_FWD
    } chk_st_e;

    typedef enum logic [1:0] {
        FR_WAIT,
        FR_TAKE,
        FR_DROP,
        FR_FIN
    } frm_st_e;

endpackage

// File: rtl/btf_req_check.sv
module btf_req_check
    import btf_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int AW        = 6,
    parameter int LEN_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_strobe,
    input  logic [LEN_W-1:0] inb_len,
    output logic [AW-1:0]    inb_addr,
    input  logic [7:0]       inb_data,
    output logic             inb_clr,
    output logic             be_req_valid,
    input  logic             be_req_ready,
    output logic [7:0]       be_req_data,
    output logic             be_req_last,
    output logic [7:0]       be_req_id,
    input  logic [7:0]       exp_id,
    input  logic             rsp_accept,
    output logic [7:0]       saved_seq,
    output logic             cap_active,
    output logic             cap_we,
    output logic [AW-1:0]    cap_addr,
    output logic [7:0]       cap_data,
    output logic             cap_done
);

    localparam int          CAP_SZ    = (BUF_BYTES > 255) ? 255 : BUF_BYTES;
    localparam logic [7:0]  CAP_SZ_B  = 8'(CAP_SZ);
    localparam int          CAP_LAST  = 9;
    localparam int          MIN_LEN   = 4;

    typedef struct packed {
        chk_st_e          st;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] idx;
        logic [7:0]       fn;
        logic [7:0]       seq;
        logic [7:0]       cmd;
        logic             pending;
    } chk_state_t;

    chk_state_t st_q, st_d;

    function automatic logic [7:0] cap_byte(input logic [LEN_W-1:0] i,
                                            input logic [7:0] fn,
                                            input logic [7:0] seq,
                                            input logic [7:0] cmd);
        logic [7:0] b;
        case (int'(i))
            0:       b = 8'd9;
            1:       b = fn | RSP_BIT;
            2:       b = seq;
            3:       b = cmd;
            4:       b = 8'd0;
            5:       b = 8'd1;
            6:       b = CAP_SZ_B;
            7:       b = CAP_SZ_B;
            8:       b = 8'd10;
            default: b = 8'd0;
        endcase
        return b;
    endfunction

    always_comb begin
        st_d         = st_q;
        inb_addr     = '0;
        inb_clr      = 1'b0;
        be_req_valid = 1'b0;
        be_req_data  = 8'd0;
        be_req_last  = 1'b0;
        cap_we       = 1'b0;
        cap_addr     = '0;
        cap_data     = 8'd0;
        cap_done     = 1'b0;

        if (rsp_accept) begin
            st_d.pending = 1'b0;
        end

        case (st_q.st)
            CK_IDLE: begin
                if (req_strobe && !st_q.pending) begin
                    st_d.len = inb_len;
                    if (int'(inb_len) >= MIN_LEN) begin
                        st_d.st = CK_LEN;
                    end
                end
            end
            CK_LEN: begin
                inb_addr = AW'(0);
                if (inb_data != 8'(st_q.len - LEN_W'(1))) begin
                    inb_clr = 1'b1;
                    st_d.st = CK_IDLE;
                end else begin
                    st_d.st = CK_FN;
                end
            end
            CK_FN: begin
                inb_addr = AW'(1);
                st_d.fn  = inb_data;
                st_d.st  = CK_SEQ;
            end
            CK_SEQ: begin
                inb_addr = AW'(2);
                st_d.seq = inb_data;
                st_d.st  = CK_CMD;
            end
            CK_CMD: begin
                inb_addr = AW'(3);
                st_d.cmd = inb_data;
                st_d.idx = '0;
                if (st_q.fn == APP_FN_BYTE && inb_data == CAP_CMD) begin
                    st_d.st = CK_CAP;
                end else begin
                    st_d.st = CK_FWD;
                end
            end
            CK_CAP: begin
                cap_we   = 1'b1;
                cap_addr = AW'(st_q.idx);
                cap_data = cap_byte(st_q.idx, st_q.fn, st_q.seq, st_q.cmd);
                if (int'(st_q.idx) == CAP_LAST) begin
                    cap_done = 1'b1;
                    st_d.st  = CK_IDLE;
                end else begin
                    st_d.idx = st_q.idx + LEN_W'(1);
                end
            end
            CK_FWD: begin
                inb_addr     = AW'(st_q.idx + LEN_W'(2));
                be_req_valid = 1'b1;
                be_req_data  = (st_q.idx == '0) ? st_q.fn : inb_data;
                be_req_last  = (st_q.idx == st_q.len - LEN_W'(3));
                if (be_req_ready) begin
                    if (be_req_last) begin
                        st_d.pending = 1'b1;
                        st_d.st      = CK_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + LEN_W'(1);
                    end
                end
            end
            default: st_d.st = CK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: CK_IDLE, len: '0, idx: '0, fn: 8'd0,
                      seq: 8'd0, cmd: 8'd0, pending: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign be_req_id  = exp_id;
    assign saved_seq  = st_q.seq;
    assign cap_active = (st_q.st == CK_CAP);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        be_req_valid && !be_req_ready |=> be_req_valid && $stable(be_req_data)
                                           && $stable(be_req_last)); // R4

    AST_SHORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == CK_IDLE) && req_strobe && (int'(inb_len) < MIN_LEN)
            |=> (st_q.st == CK_IDLE)); // R1

    AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending && !rsp_accept && req_strobe |=> !be_req_valid && !inb_clr); // R10

endmodule

// File: rtl/btf_rsp_frame.sv
module btf_rsp_frame
    import btf_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int AW        = 6,
    parameter int LEN_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_last,
    input  logic [7:0]       rsp_id,
    input  logic [7:0]       saved_seq,
    output logic [7:0]       exp_id,
    output logic             rsp_accept,
    output logic             fr_we,
    output logic [AW-1:0]    fr_addr,
    output logic [7:0]       fr_data,
    output logic             fr_done,
    output logic [LEN_W-1:0] fr_len
);

    localparam int            CNT_W    = AW + 2;
    localparam int            MAX_BODY = BUF_BYTES - 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int            ERR_STEPS = 5;

    typedef struct packed {
        frm_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       step;
        logic [7:0]       fn;
        logic [7:0]       cmd;
        logic [7:0]       exp;
    } frm_state_t;

    frm_state_t fq, fd;
    logic       beat;
    logic       over;

    always_comb begin
        fd         = fq;
        fr_we      = 1'b0;
        fr_addr    = '0;
        fr_data    = 8'd0;
        fr_done    = 1'b0;
        fr_len     = '0;
        rsp_accept = 1'b0;
        rsp_ready  = (fq.st != FR_FIN) && !hold;
        beat       = rsp_valid && rsp_ready;
        over       = int'(fq.cnt) > MAX_BODY;

        case (fq.st)
            FR_WAIT: begin
                if (beat) begin
                    if (rsp_id == fq.exp) begin
                        fr_we   = 1'b1;
                        fr_addr = AW'(1);
                        fr_data = rsp_data;
                        fd.fn   = rsp_data;
                        fd.cmd  = 8'd0;
                        fd.cnt  = CNT_W'(1);
                        fd.step = 3'd0;
                        fd.st   = rsp_last ? FR_FIN : FR_TAKE;
                    end else begin
                        fd.st   = rsp_last ? FR_WAIT : FR_DROP;
                    end
                end
            end
            FR_TAKE: begin
                if (beat) begin
                    if (int'(fq.cnt) + 2 < BUF_BYTES) begin
                        fr_we   = 1'b1;
                        fr_addr = AW'(fq.cnt + CNT_W'(2));
                        fr_data = rsp_data;
                    end
                    if (fq.cnt == CNT_W'(1)) begin
                        fd.cmd = rsp_data;
                    end
                    if (fq.cnt != CNT_MAX) begin
                        fd.cnt = fq.cnt + CNT_W'(1);
                    end
                    if (rsp_last) begin
                        fd.step = 3'd0;
                        fd.st   = FR_FIN;
                    end
                end
            end
            FR_DROP: begin
                if (beat && rsp_last) begin
                    fd.st = FR_WAIT;
                end
            end
            FR_FIN: begin
                fr_we = 1'b1;
                if (over) begin
                    fr_addr = AW'(fq.step);
                    case (fq.step)
                        3'd0:    fr_data = 8'd4;
                        3'd1:    fr_data = fq.fn;
                        3'd2:    fr_data = saved_seq;
                        3'd3:    fr_data = fq.cmd;
                        default: fr_data = CC_TOO_BIG;
                    endcase
                end else begin
                    fr_addr = (fq.step == 3'd0) ? AW'(0) : AW'(2);
                    fr_data = (fq.step == 3'd0) ? 8'(fq.cnt + CNT_W'(1)) : saved_seq;
                end
                if ((over && int'(fq.step) == ERR_STEPS - 1) ||
                    (!over && fq.step == 3'd1)) begin
                    fr_done    = 1'b1;
                    fr_len     = over ? LEN_W'(ERR_STEPS) : LEN_W'(fq.cnt + CNT_W'(2));
                    rsp_accept = 1'b1;
                    fd.exp     = fq.exp + 8'd1;
                    fd.st      = FR_WAIT;
                end else begin
                    fd.step = fq.step + 3'd1;
                end
            end
            default: fd.st = FR_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq <= '{st: FR_WAIT, cnt: '0, step: 3'd0, fn: 8'd0, cmd: 8'd0, exp: 8'd0};
        end else begin
            fq <= fd;
        end
    end

    assign exp_id = fq.exp;

    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_accept |=> exp_id == $past(exp_id) + 8'd1); // R5

    AST_FOREIGN_ID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        beat && (fq.st == FR_WAIT) && (rsp_id != exp_id) |=> $stable(exp_id)); // R9

    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fq.st == FR_DROP) |-> !fr_we && !fr_done); // R9

endmodule

// File: rtl/btf_frame_engine.sv
module btf_frame_engine
    import btf_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_strobe,
    input  logic [LEN_W-1:0] inb_len,
    output logic [AW-1:0]    inb_addr,
    input  logic [7:0]       inb_data,
    output logic             inb_clr,
    output logic             be_req_valid,
    input  logic             be_req_ready,
    output logic [7:0]       be_req_data,
    output logic             be_req_last,
    output logic [7:0]       be_req_id,
    input  logic             be_rsp_valid,
    output logic             be_rsp_ready,
    input  logic [7:0]       be_rsp_data,
    input  logic             be_rsp_last,
    input  logic [7:0]       be_rsp_id,
    output logic             ob_we,
    output logic [AW-1:0]    ob_addr,
    output logic [7:0]       ob_data,
    output logic             ob_len_we,
    output logic [LEN_W-1:0] ob_len,
    output logic             reply_done
);

    logic [7:0]       exp_id;
    logic             rsp_accept;
    logic [7:0]       saved_seq;
    logic             cap_active;
    logic             cap_we;
    logic [AW-1:0]    cap_addr;
    logic [7:0]       cap_data;
    logic             cap_done;
    logic             fr_we;
    logic [AW-1:0]    fr_addr;
    logic [7:0]       fr_data;
    logic             fr_done;
    logic [LEN_W-1:0] fr_len;

    btf_req_check #(.BUF_BYTES(BUF_BYTES), .AW(AW), .LEN_W(LEN_W)) u_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_strobe   (req_strobe),
        .inb_len      (inb_len),
        .inb_addr     (inb_addr),
        .inb_data     (inb_data),
        .inb_clr      (inb_clr),
        .be_req_valid (be_req_valid),
        .be_req_ready (be_req_ready),
        .be_req_data  (be_req_data),
        .be_req_last  (be_req_last),
        .be_req_id    (be_req_id),
        .exp_id       (exp_id),
        .rsp_accept   (rsp_accept),
        .saved_seq    (saved_seq),
        .cap_active   (cap_active),
        .cap_we       (cap_we),
        .cap_addr     (cap_addr),
        .cap_data     (cap_data),
        .cap_done     (cap_done)
    );

    btf_rsp_frame #(.BUF_BYTES(BUF_BYTES), .AW(AW), .LEN_W(LEN_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (cap_active),
        .rsp_valid  (be_rsp_valid),
        .rsp_ready  (be_rsp_ready),
        .rsp_data   (be_rsp_data),
        .rsp_last   (be_rsp_last),
        .rsp_id     (be_rsp_id),
        .saved_seq  (saved_seq),
        .exp_id     (exp_id),
        .rsp_accept (rsp_accept),
        .fr_we      (fr_we),
        .fr_addr    (fr_addr),
        .fr_data    (fr_data),
        .fr_done    (fr_done),
        .fr_len     (fr_len)
    );

    always_comb begin
        if (cap_active) begin
            ob_we   = cap_we;
            ob_addr = cap_addr;
            ob_data = cap_data;
        end else begin
            ob_we   = fr_we;
            ob_addr = fr_addr;
            ob_data = fr_data;
        end
        reply_done = cap_done | fr_done;
        ob_len_we  = cap_done | fr_done;
        ob_len     = cap_done ? LEN_W'(10) : fr_len;
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_we && fr_we)); // R3

    AST_DONE_WITH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        reply_done |-> ob_len_we && (int'(ob_len) <= BUF_BYTES)); // R8

endmodule

// File: tb/btf_frame_engine_bench.sv
module btf_frame_engine_bench;

    localparam int BUF   = 64;
    localparam int AW    = $clog2(BUF);
    localparam int LEN_W = $clog2(BUF + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_strobe = 1'b0;
    logic [LEN_W-1:0] inb_len = '0;
    logic [AW-1:0]    inb_addr;
    logic [7:0]       inb_data;
    logic             inb_clr;
    logic             be_req_valid;
    logic             be_req_ready = 1'b1;
    logic [7:0]       be_req_data;
    logic             be_req_last;
    logic [7:0]       be_req_id;
    logic             be_rsp_valid = 1'b0;
    logic             be_rsp_ready;
    logic [7:0]       be_rsp_data = 8'd0;
    logic             be_rsp_last = 1'b0;
    logic [7:0]       be_rsp_id = 8'd0;
    logic             ob_we;
    logic [AW-1:0]    ob_addr;
    logic [7:0]       ob_data;
    logic             ob_len_we;
    logic [LEN_W-1:0] ob_len;
    logic             reply_done;

    logic [7:0] inb_mem [BUF];
    logic [7:0] ob_mem  [BUF];
    logic [7:0] rsp_buf [128];
    logic [7:0] beat_d  [BUF];
    logic       beat_l  [BUF];
    logic [7:0] beat_id [BUF];

    int n_checks = 0;
    int n_fail   = 0;
    int n_clr    = 0;
    int n_done   = 0;
    int n_obw    = 0;
    int n_beats  = 0;
    int last_len = 0;
    logic [7:0] bexp = 8'd0;

    always #10 clk = ~clk;

    assign inb_data = inb_mem[inb_addr];

    btf_frame_engine #(.BUF_BYTES(BUF)) u_btf_frame_engine (
        .clk (clk), .rst_n (rst_n), .req_strobe (req_strobe), .inb_len (inb_len),
        .inb_addr (inb_addr), .inb_data (inb_data), .inb_clr (inb_clr),
        .be_req_valid (be_req_valid), .be_req_ready (be_req_ready),
        .be_req_data (be_req_data), .be_req_last (be_req_last), .be_req_id (be_req_id),
        .be_rsp_valid (be_rsp_valid), .be_rsp_ready (be_rsp_ready),
        .be_rsp_data (be_rsp_data), .be_rsp_last (be_rsp_last), .be_rsp_id (be_rsp_id),
        .ob_we (ob_we), .ob_addr (ob_addr), .ob_data (ob_data),
        .ob_len_we (ob_len_we), .ob_len (ob_len), .reply_done (reply_done)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (ob_we) begin
                ob_mem[ob_addr] <= ob_data;
                n_obw <= n_obw + 1;
            end
            if (ob_len_we) last_len <= int'(ob_len);
            if (reply_done) n_done <= n_done + 1;
            if (inb_clr) n_clr <= n_clr + 1;
            if (be_req_valid && be_req_ready) begin
                beat_d[n_beats % BUF]  <= be_req_data;
                beat_l[n_beats % BUF]  <= be_req_last;
                beat_id[n_beats % BUF] <= be_req_id;
                n_beats <= n_beats + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input int ln);
        @(negedge clk);
        inb_len    = LEN_W'(ln);
        req_strobe = 1'b1;
        @(negedge clk);
        req_strobe = 1'b0;
        repeat (ln + 20) @(negedge clk);
    endtask

    task automatic load_req(input logic [7:0] fn, input logic [7:0] seq,
                            input logic [7:0] cmd, input int ln);
        inb_mem[0] = 8'(ln - 1);
        inb_mem[1] = fn;
        inb_mem[2] = seq;
        inb_mem[3] = cmd;
        for (int i = 4; i < ln; i++) inb_mem[i] = 8'(8'h40 + i);
    endtask

    task automatic send_rsp(input logic [7:0] id, input int n);
        for (int i = 0; i < n; i++) begin
            be_rsp_valid = 1'b1;
            be_rsp_data  = rsp_buf[i];
            be_rsp_last  = (i == n - 1);
            be_rsp_id    = id;
            while (1) begin
                if (be_rsp_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        be_rsp_valid = 1'b0;
        be_rsp_last  = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("reset req_valid", int'(be_req_valid), 0);
        chk("reset reply_done", int'(reply_done), 0);
        chk("reset ob_we", int'(ob_we), 0);
        chk("reset rsp_ready", int'(be_rsp_ready), 1);
    endtask

    task automatic t_short;
        int c0 = n_clr, b0 = n_beats, d0 = n_done, w0 = n_obw;
        inb_mem[0] = 8'd5; inb_mem[1] = 8'h18; inb_mem[2] = 8'h01; inb_mem[3] = 8'h36;
        strobe(3);
        chk("R1 short no clear", n_clr, c0);
        chk("R1 short no beats", n_beats, b0);
        chk("R1 short no done/write", n_done + n_obw, d0 + w0);
    endtask

    task automatic t_mismatch;
        int c0 = n_clr, b0 = n_beats, d0 = n_done;
        load_req(8'h1C, 8'h22, 8'h01, 6);
        inb_mem[0] = 8'd7;
        strobe(6);
        chk("R2 mismatch clears once", n_clr, c0 + 1);
        chk("R2 mismatch no beats", n_beats, b0);
        chk("R2 mismatch no done", n_done, d0);
    endtask

    task automatic t_cap;
        int d0 = n_done, b0 = n_beats;
        logic [7:0] exp [10];
        exp = '{8'd9, 8'h1C, 8'h5A, 8'h36, 8'd0, 8'd1, 8'(BUF), 8'(BUF), 8'd10, 8'd0};
        load_req(8'h18, 8'h5A, 8'h36, 4);
        strobe(4);
        for (int i = 0; i < 10; i++) chk($sformatf("R3 cap byte %0d", i), int'(ob_mem[i]), int'(exp[i]));
        chk("R3 cap length", last_len, 10);
        chk("R8 cap done pulse", n_done, d0 + 1);
        chk("R3 cap not forwarded", n_beats, b0);
    endtask

    task automatic t_forward;
        int b0 = n_beats;
        load_req(8'h1C, 8'h33, 8'h01, 6);
        strobe(6);
        chk("R4 beat count", n_beats - b0, 4);
        chk("R4 beat0 fn", int'(beat_d[b0 % BUF]), 8'h1C);
        chk("R4 beat1 cmd", int'(beat_d[(b0 + 1) % BUF]), 8'h01);
        chk("R4 beat3 data", int'(beat_d[(b0 + 3) % BUF]), 8'h45);
        chk("R4 last only at end", int'(beat_l[(b0 + 2) % BUF]) * 2 + int'(beat_l[(b0 + 3) % BUF]), 1);
        chk("R4 id tag", int'(beat_id[b0 % BUF]), int'(bexp));
    endtask

    task automatic t_pending;
        int b0 = n_beats, c0 = n_clr;
        load_req(8'h20, 8'h77, 8'h02, 4);
        strobe(4);
        chk("R10 pending blocks forward", n_beats, b0);
        chk("R10 pending no clear", n_clr, c0);
        load_req(8'h1C, 8'h33, 8'h01, 6);
    endtask

    task automatic t_bad_id;
        int w0 = n_obw, d0 = n_done;
        rsp_buf[0] = 8'h1C; rsp_buf[1] = 8'h01; rsp_buf[2] = 8'h00;
        send_rsp(bexp + 8'd3, 3);
        chk("R9 foreign id no write", n_obw, w0);
        chk("R9 foreign id no done", n_done, d0);
    endtask

    task automatic t_normal;
        int d0 = n_done;
        rsp_buf[0] = 8'h1C; rsp_buf[1] = 8'h01; rsp_buf[2] = 8'h00;
        rsp_buf[3] = 8'h11; rsp_buf[4] = 8'h22;
        send_rsp(bexp, 5);
        bexp++;
        chk("R6 len byte", int'(ob_mem[0]), 6);
        chk("R6 fn byte", int'(ob_mem[1]), 8'h1C);
        chk("R6 seq restored", int'(ob_mem[2]), 8'h33);
        chk("R6 cmd byte", int'(ob_mem[3]), 8'h01);
        chk("R6 tail byte", int'(ob_mem[6]), 8'h22);
        chk("R6 frame length", last_len, 7);
        chk("R9 R8 accepted after foreign", n_done, d0 + 1);
    endtask

    task automatic t_sizes;
        // boundary: exactly BUF-2 bytes fits
        load_req(8'h2C, 8'h91, 8'h05, 4);
        strobe(4);
        for (int i = 0; i < BUF - 2; i++) rsp_buf[i] = 8'(i + 8'h80);
        rsp_buf[0] = 8'h2C; rsp_buf[1] = 8'h05;
        send_rsp(bexp, BUF - 2);
        bexp++;
        chk("R6 boundary len byte", int'(ob_mem[0]), BUF - 1);
        chk("R6 boundary seq", int'(ob_mem[2]), 8'h91);
        chk("R6 boundary last byte", int'(ob_mem[BUF - 1]), int'(rsp_buf[BUF - 3]));
        chk("R6 boundary length", last_len, BUF);
        // one more byte: error frame
        load_req(8'h2C, 8'h92, 8'h06, 4);
        strobe(4);
        rsp_buf[0] = 8'h2C; rsp_buf[1] = 8'h06;
        send_rsp(bexp, BUF - 1);
        bexp++;
        chk("R7 err len", int'(ob_mem[0]), 4);
        chk("R7 err fn", int'(ob_mem[1]), 8'h2C);
        chk("R7 err seq", int'(ob_mem[2]), 8'h92);
        chk("R7 err cmd", int'(ob_mem[3]), 8'h06);
        chk("R7 err code", int'(ob_mem[4]), 8'hCA);
        chk("R7 err length", last_len, 5);
    endtask

    task automatic t_wrap;
        int bad = 0;
        for (int k = 0; k < 256; k++) begin
            int b0 = n_beats;
            load_req(8'h30, 8'(k), 8'h07, 4);
            strobe(4);
            if (n_beats != b0 + 2 || beat_id[b0 % BUF] != bexp) bad++;
            rsp_buf[0] = 8'h30; rsp_buf[1] = 8'h07;
            send_rsp(bexp, 2);
            bexp++;
        end
        chk("R5 ids over 256 round trips", bad, 0);
        load_req(8'h30, 8'h01, 8'h07, 4);
        begin
            int b0 = n_beats;
            strobe(4);
            chk("R5 id after wrap", int'(beat_id[b0 % BUF]), int'(bexp));
        end
    endtask

    initial begin
        for (int i = 0; i < BUF; i++) begin
            inb_mem[i] = 8'd0;
            ob_mem[i]  = 8'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_short;
        t_mismatch;
        t_cap;
        t_forward;
        t_pending;
        t_bad_id;
        t_normal;
        t_sizes;
        t_wrap;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule